// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a flash-style memory controller. It watches single-cycle write strobes, each carrying an address and an 8-bit data byte, and recognises the multi-write unlock sequences that select program, chip erase, sector erase, sector lockout, bypass-mode entry, erase suspend, erase resume and product-identification entry or exit. When a sequence completes it issues a one-clock command pulse that carries a command code together with the address and data of the final write. The embedded timers and the memory array sit downstream and report completion on `done_i`.

Besides the sequencer, the block keeps four mode flags that change how later writes are read: a sticky bypass mode in which each single write is a program, an identification mode, a busy flag for a running program or erase, and a suspended flag for a paused erase. Reads need no command. They are served whenever the sequencer is idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command matching compares only address bits 15..0 and data bits 7..0. The unlock prefix is data AA at address 5555 followed by data 55 at address 2AAA. Address bits above bit 15 never affect recognition.
- R2: The prefix, then A0 at 5555, then one more write issues `cmd_o`=1 (program), with that last write's address and data.
- R3: The prefix, then 80 at 5555, AA at 5555 and 55 at 2AAA, form a five-write erase header. After the header, 10 at 5555 issues `cmd_o`=2 (chip erase) and 30 at any address issues `cmd_o`=3 (sector erase) carrying that address.
- R4: After the erase header, 40 at any address issues `cmd_o`=4 (sector lockout) and A0 at 5555 issues `cmd_o`=5 (bypass entry). Bypass entry sets `bypass_o`.
- R5: The prefix then 90 at 5555 issues `cmd_o`=8 and sets `id_mode_o`. A single write of F0 at any address, or the prefix then F0 at 5555, issues `cmd_o`=9 and clears `id_mode_o`.
- R6: While an erase is running, a single write of B0 at any address issues `cmd_o`=6 (suspend). It sets `susp_o` and clears `busy_o`.
- R7: While suspended and not busy, a single write of 30 issues `cmd_o`=7 (resume). Its address, plane bits 19..18 included, goes out on `cmd_addr_o`. Resume clears `susp_o` and sets `busy_o`.
- R8: In bypass mode every accepted write issues `cmd_o`=1 with its own address and data, including B0, 30 and AA. Only reset clears `bypass_o`.
- R9: A program, erase or resume command sets `busy_o`, and `done_i` clears it. While busy, every write is ignored. The one exception is a suspend write during an erase.
- R10: While suspended, a chip or sector erase sequence issues no command. A program is still accepted and sets `busy_o`.
- R11: A write that does not match the next expected step of a sequence returns the sequencer to idle and issues no command.
- R12: `rst_ni` low clears all flags and `cmd_valid_o` and returns the sequencer to idle. A partly entered sequence is lost.
- R13: `cmd_valid_o` is high for exactly the one clock that follows the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one clock per bus write |
| addr_i | input | AW (20) | Write address |
| data_i | input | 8 | Write data |
| done_i | input | 1 | Embedded program or erase finished |
| cmd_valid_o | output | 1 | Command pulse |
| cmd_o | output | 4 | Command code (see requirements) |
| cmd_addr_o | output | AW (20) | Address of the completing write |
| cmd_data_o | output | 8 | Data of the completing write |
| bypass_o | output | 1 | Single-write program mode active |
| id_mode_o | output | 1 | Identification mode active |
| busy_o | output | 1 | Program or erase running |
| susp_o | output | 1 | Erase suspended |

## Verification
If the sequencer state is corrupted, a valid sequence produces no pulse, or a stray pulse appears, on the clock after the final write. If a mode flag is corrupted, later writes are read the wrong way: an erase accepted while suspended, a bypass write that issues no program, or a write that is acted on while busy. These faults show up at the first write after the bad state, together with a flag that differs from the expected value. The stimulus therefore follows every state change with a probing write whose outcome is known in advance.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned KEY_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [KEY_W-1:0] KEY_ADR_A = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_ADR_B = 16'h2AAA;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_PROG       = 4'd1,
    CMD_CHIP_ERASE = 4'd2,
    CMD_SECT_ERASE = 4'd3,
    CMD_LOCK       = 4'd4,
    CMD_BYPASS     = 4'd5,
    CMD_SUSPEND    = 4'd6,
    CMD_RESUME     = 4'd7,
    CMD_ID_ENTER   = 4'd8,
    CMD_ID_EXIT    = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_e;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_f0;
    logic d_10;
    logic d_30;
    logic d_40;
    logic d_b0;
  } hit_t;
endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [KEY_W-1:0]  key_i,
  input  logic [BYTE_W-1:0] data_i,
  output hit_t              hit_o
);
  always_comb begin
    hit_o.at_a = (key_i == KEY_ADR_A);
    hit_o.at_b = (key_i == KEY_ADR_B);
    hit_o.d_aa = (data_i == 8'hAA);
    hit_o.d_55 = (data_i == 8'h55);
    hit_o.d_a0 = (data_i == 8'hA0);
    hit_o.d_80 = (data_i == 8'h80);
    hit_o.d_90 = (data_i == 8'h90);
    hit_o.d_f0 = (data_i == 8'hF0);
    hit_o.d_10 = (data_i == 8'h10);
    hit_o.d_30 = (data_i == 8'h30);
    hit_o.d_40 = (data_i == 8'h40);
    hit_o.d_b0 = (data_i == 8'hB0);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  hit_t hit_i,
  input  logic bypass_i,
  input  op_e  op_i,
  input  logic susp_i,
  output cmd_e cmd_d_o
);
  seq_e st_q, st_d;
  logic accept;

  // only a suspend gets through a running erase; a running program blocks all
  assign accept = wr_i && ((op_i == OP_NONE) ||
                           (op_i == OP_ERASE && hit_i.d_b0 && !bypass_i));

  always_comb begin
    st_d    = st_q;
    cmd_d_o = CMD_NONE;
    if (accept) begin
      st_d = SQ_IDLE;
      if (bypass_i) begin
        cmd_d_o = CMD_PROG;
      end else begin
        case (st_q)
          SQ_IDLE: begin
            if (op_i == OP_ERASE)          cmd_d_o = CMD_SUSPEND;
            else if (hit_i.d_f0)           cmd_d_o = CMD_ID_EXIT;
            else if (hit_i.d_30 && susp_i) cmd_d_o = CMD_RESUME;
            else if (hit_i.at_a && hit_i.d_aa) st_d = SQ_U1;
          end
          SQ_U1: if (hit_i.at_b && hit_i.d_55) st_d = SQ_U2;
          SQ_U2: if (hit_i.at_a) begin
            if (hit_i.d_a0)      st_d = SQ_PGM;
            else if (hit_i.d_80) st_d = SQ_E3;
            else if (hit_i.d_90) cmd_d_o = CMD_ID_ENTER;
            else if (hit_i.d_f0) cmd_d_o = CMD_ID_EXIT;
          end
          SQ_PGM: cmd_d_o = CMD_PROG;
          SQ_E3:  if (hit_i.at_a && hit_i.d_aa) st_d = SQ_E4;
          SQ_E4:  if (hit_i.at_b && hit_i.d_55) st_d = SQ_E5;
          SQ_E5: begin
            if (hit_i.at_a && hit_i.d_10 && !susp_i) cmd_d_o = CMD_CHIP_ERASE;
            else if (hit_i.d_30 && !susp_i)          cmd_d_o = CMD_SECT_ERASE;
            else if (hit_i.d_40)                     cmd_d_o = CMD_LOCK;
            else if (hit_i.at_a && hit_i.d_a0)       cmd_d_o = CMD_BYPASS;
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_d_i,
  input  logic done_i,
  output logic bypass_o,
  output logic id_mode_o,
  output op_e  op_o,
  output logic susp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_o  <= 1'b0;
      id_mode_o <= 1'b0;
      op_o      <= OP_NONE;
      susp_o    <= 1'b0;
    end else begin
      case (cmd_d_i)
        CMD_PROG:                                   op_o <= OP_PROG;
        CMD_CHIP_ERASE, CMD_SECT_ERASE, CMD_RESUME: op_o <= OP_ERASE;
        CMD_SUSPEND:                                op_o <= OP_NONE;
        default: if (done_i)                        op_o <= OP_NONE;
      endcase
      if (cmd_d_i == CMD_SUSPEND)  susp_o    <= 1'b1;
      if (cmd_d_i == CMD_RESUME)   susp_o    <= 1'b0;
      if (cmd_d_i == CMD_BYPASS)   bypass_o  <= 1'b1;
      if (cmd_d_i == CMD_ID_ENTER) id_mode_o <= 1'b1;
      if (cmd_d_i == CMD_ID_EXIT)  id_mode_o <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              done_i,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_o,
  output logic [AW-1:0]     cmd_addr_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              bypass_o,
  output logic              id_mode_o,
  output logic              busy_o,
  output logic              susp_o
);
  hit_t hit;
  cmd_e cmd_d;
  op_e  op;

  flash_cmd_match u_match (
    .key_i  (addr_i[KEY_W-1:0]),
    .data_i (data_i),
    .hit_o  (hit)
  );

  flash_cmd_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .hit_i    (hit),
    .bypass_i (bypass_o),
    .op_i     (op),
    .susp_i   (susp_o),
    .cmd_d_o  (cmd_d)
  );

  flash_cmd_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_d_i   (cmd_d),
    .done_i    (done_i),
    .bypass_o  (bypass_o),
    .id_mode_o (id_mode_o),
    .op_o      (op),
    .susp_o    (susp_o)
  );

  assign busy_o = (op != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_o       <= CMD_NONE;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= (cmd_d != CMD_NONE);
      cmd_o       <= cmd_d;
      if (cmd_d != CMD_NONE) begin
        cmd_addr_o <= addr_i;
        cmd_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [7:0] data_i,
  input logic       cmd_valid_o,
  input logic [3:0] cmd_o,
  input logic       bypass_o,
  input logic       busy_o,
  input logic       susp_o
);
  AST_BYPASS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |=> bypass_o); // R8
  AST_BYPASS_ONLY_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_o && cmd_valid_o && cmd_o != 4'd5) |-> cmd_o == 4'd1); // R8
  AST_PROG_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 4'd1) |-> busy_o); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o && data_i != 8'hB0) |=> !cmd_valid_o); // R9
  AST_NO_ERASE_IN_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |=> !(cmd_valid_o && (cmd_o == 4'd2 || cmd_o == 4'd3))); // R10
  AST_SUSPEND_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 4'd6) |-> (susp_o && !busy_o)); // R6
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .data_i      (data_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_o       (cmd_o),
  .bypass_o    (bypass_o),
  .busy_o      (busy_o),
  .susp_o      (susp_o)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam logic [3:0] C_PROG = 4'd1, C_CHIP = 4'd2, C_SECT = 4'd3, C_LOCK = 4'd4,
                         C_BYP = 4'd5, C_SUSP = 4'd6, C_RES = 4'd7, C_IDIN = 4'd8,
                         C_IDOUT = 4'd9;

  logic clk = 1'b0, rst_n = 1'b0, wr_i = 1'b0, done_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic cmd_valid_o, bypass_o, id_mode_o, busy_o, susp_o;
  logic [3:0]  cmd_o;
  logic [19:0] cmd_addr_o;
  logic [7:0]  cmd_data_o;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R12";
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  flash_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .done_i(done_i), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o), .cmd_addr_o(cmd_addr_o),
    .cmd_data_o(cmd_data_o), .bypass_o(bypass_o), .id_mode_o(id_mode_o),
    .busy_o(busy_o), .susp_o(susp_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected commands as pulses appear
  always @(negedge clk) begin
    if (rst_n && cmd_valid_o) begin
      logic [31:0] got;
      got = {cmd_o, cmd_addr_o, cmd_data_o};
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected command", got, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, "command", got, e);
      end
    end
  end

  task automatic expect_cmd(input logic [3:0] c, input logic [19:0] a,
                            input logic [7:0] d, input string tag);
    exp_q.push_back({c, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic prefix();
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
  endtask

  task automatic erase_hdr();
    prefix();
    wr(20'h05555, 8'h80);
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
  endtask

  task automatic finish_op();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic flags(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {bypass_o, id_mode_o, busy_o, susp_o};
    chk(act == exp, tag, "flags{byp,id,busy,susp}", {28'h0, act}, {28'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R13", "watchdog expired", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R12";
    chk({cmd_valid_o, bypass_o, id_mode_o, busy_o, susp_o} == 5'b0, "R12",
        "outputs in reset", {27'h0, cmd_valid_o, bypass_o, id_mode_o, busy_o, susp_o}, 32'h0);
    rst_n = 1'b1;

    // R2 program, R13 single pulse
    cur_req = "R2";
    prefix(); wr(20'h05555, 8'hA0);
    expect_cmd(C_PROG, 20'h01234, 8'h5A, "R2");
    wr(20'h01234, 8'h5A);
    @(negedge clk);
    chk(cmd_valid_o == 1'b0, "R13", "pulse width", {31'h0, cmd_valid_o}, 32'h0);
    flags(4'b0010, "R9");

    // R9: writes while programming are dropped; sequencer must not advance
    cur_req = "R9";
    wr(20'h05555, 8'hAA);
    finish_op();
    flags(4'b0000, "R9");
    wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
    flags(4'b0000, "R9");

    // R1 upper address bits ignored; R5 id entry/exit
    cur_req = "R1";
    wr(20'h35555, 8'hAA); wr(20'h82AAA, 8'h55);
    expect_cmd(C_IDIN, 20'hF5555, 8'h90, "R1");
    wr(20'hF5555, 8'h90);
    flags(4'b0100, "R5");
    cur_req = "R5";
    expect_cmd(C_IDOUT, 20'h7A0B1, 8'hF0, "R5");
    wr(20'h7A0B1, 8'hF0);
    flags(4'b0000, "R5");
    prefix(); expect_cmd(C_IDIN, 20'h05555, 8'h90, "R5"); wr(20'h05555, 8'h90);
    prefix(); expect_cmd(C_IDOUT, 20'h05555, 8'hF0, "R5"); wr(20'h05555, 8'hF0);
    flags(4'b0000, "R5");

    // R11 mismatch returns to idle
    cur_req = "R11";
    prefix(); wr(20'h05555, 8'h77);
    wr(20'h05555, 8'hA0); wr(20'h01000, 8'h12);
    flags(4'b0000, "R11");

    // R3 chip erase, R6 suspend, R10, R7 resume
    cur_req = "R3";
    erase_hdr();
    expect_cmd(C_CHIP, 20'h05555, 8'h10, "R3");
    wr(20'h05555, 8'h10);
    flags(4'b0010, "R3");
    cur_req = "R9";
    wr(20'h05555, 8'hAA);
    cur_req = "R6";
    expect_cmd(C_SUSP, 20'h12345, 8'hB0, "R6");
    wr(20'h12345, 8'hB0);
    flags(4'b0001, "R6");
    cur_req = "R10";
    prefix(); wr(20'h05555, 8'hA0);
    expect_cmd(C_PROG, 20'h0ABCD, 8'h3C, "R10");
    wr(20'h0ABCD, 8'h3C);
    flags(4'b0011, "R10");
    finish_op();
    erase_hdr(); wr(20'h48000, 8'h30);
    flags(4'b0001, "R10");
    erase_hdr(); wr(20'h05555, 8'h10);
    flags(4'b0001, "R10");
    cur_req = "R7";
    expect_cmd(C_RES, 20'hC0000, 8'h30, "R7");
    wr(20'hC0000, 8'h30);
    flags(4'b0010, "R7");
    finish_op();

    // R3 sector erase, R4 lockout
    cur_req = "R3";
    erase_hdr();
    expect_cmd(C_SECT, 20'h48000, 8'h30, "R3");
    wr(20'h48000, 8'h30);
    flags(4'b0010, "R3");
    finish_op();
    cur_req = "R4";
    erase_hdr();
    expect_cmd(C_LOCK, 20'hF8000, 8'h40, "R4");
    wr(20'hF8000, 8'h40);
    flags(4'b0000, "R4");

    // R12 reset mid-sequence and mid-program
    cur_req = "R12";
    wr(20'h05555, 8'hAA);
    do_reset();
    wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
    flags(4'b0000, "R12");
    prefix(); wr(20'h05555, 8'hA0);
    expect_cmd(C_PROG, 20'h00100, 8'h55, "R12");
    wr(20'h00100, 8'h55);
    do_reset();
    flags(4'b0000, "R12");

    // R4 bypass entry, R8 single-write programs
    cur_req = "R4";
    erase_hdr();
    expect_cmd(C_BYP, 20'h05555, 8'hA0, "R4");
    wr(20'h05555, 8'hA0);
    flags(4'b1000, "R4");
    cur_req = "R8";
    expect_cmd(C_PROG, 20'h00010, 8'hB0, "R8"); wr(20'h00010, 8'hB0); finish_op();
    expect_cmd(C_PROG, 20'h80000, 8'h30, "R8"); wr(20'h80000, 8'h30); finish_op();
    expect_cmd(C_PROG, 20'h05555, 8'hAA, "R8"); wr(20'h05555, 8'hAA); finish_op();
    flags(4'b1000, "R8");
    do_reset();
    flags(4'b0000, "R8");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R13", "missing commands", exp_q.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule